// File: doc/BRIEF.md
# ECC Write-Path Error Injector

This block sits in the write path of a memory controller, between the ECC encoder and the memory interface. It lets software corrupt the check bits of exactly one future write beat so that the controller's correctable and uncorrectable error reporting can be tested end to end. Software programs an 8-bit XOR pattern, an optional writeback enable and a force (arm) bit through a small register bus. Once the injector is armed, it XORs the pattern into the check bits of the next valid write beat. It then disarms itself.

Software picks the pattern. To flip one data bit, it writes that bit's column of the encoder's parity matrix. To flip check bit k, it writes `1 << k` (k from 0 to 7). To get a double-bit (uncorrectable) error, it writes `0x03` and leaves writeback disabled. Data bits are numbered 0 to 63. The arm bit only takes effect while the controller reports idle, so an injection can never land on a write that was already in flight when software asked for it.

Beats pass through one register stage. Data bits and the valid flag are never altered.

Top module: `ecc_inject_ctrl`

## Requirements
- R1: After reset, the control word reads 0x00000000, `wr_valid_o` is 0 and `wb_en_o` is 0.
- R2: The control word is at byte offset 0x0. It holds the XOR pattern in bits 23:16, the writeback enable in bit 24 and the arm bit in bit 8. All other bits read 0, and a write stores only those three fields.
- R3: The status word is at byte offset 0x4. Bit 0 of it shows the `busy_i` input, and all other bits read 0. Writes to this offset have no effect.
- R4: While `busy_i` is 1, a control write leaves the arm bit unchanged. The pattern and writeback fields are still updated. A write beat that follows such a write passes through unmodified.
- R5: While the injector is not armed, every beat comes out one cycle later with valid, data and check bits equal to the input.
- R6: While the injector is armed, the next valid beat comes out one cycle later with its check bits XORed with the pattern. Its data is unchanged.
- R7: The arm bit clears in the same clock edge that registers the corrupted beat. The control word then reads the arm bit as 0, and the following beat is unmodified.
- R8: Clock cycles with `wr_valid_i` low do not use up the arming.
- R9: `wb_en_o` equals control bit 24. It changes only on a control write.
- R10: Suppose a control write that sets the arm bit while idle lands in the same cycle as the beat that disarms the injector. That beat is corrupted with the old pattern, and the injector stays armed with the new pattern.
- R11: A write to any offset other than 0x0 changes no register. A read from such an offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset for both reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the word at `reg_addr` (combinational) |
| busy_i | input | 1 | Memory controller has writes pending |
| wr_valid_i | input | 1 | Incoming write beat valid |
| wr_data_i | input | 64 | Incoming write data |
| wr_check_i | input | 8 | Incoming ECC check bits |
| wr_valid_o | output | 1 | Outgoing write beat valid |
| wr_data_o | output | 64 | Outgoing write data |
| wr_check_o | output | 8 | Outgoing check bits, corrupted when the injector is armed |
| wb_en_o | output | 1 | Writeback enable toward the controller |

## Verification
A beat that is presented before a clock edge appears at the outputs right after that edge. The bench therefore drives each beat on a falling edge and compares the outputs on the next falling edge. A register write is captured on the same edge, and the read port is combinational. This means the control word, including the self-cleared arm bit, is read back at the falling edge that follows the write or the consuming beat. The same-cycle collision and the busy case are each checked at that single falling edge, first on the beat and then on the readback.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;

    localparam int REG_W     = 32;
    localparam int PAT_W     = 8;
    localparam int PAT_LSB   = 16;
    localparam int WB_BIT    = 24;
    localparam int ARM_BIT   = 8;
    localparam int BUSY_BIT  = 0;

    typedef struct packed {
        logic [PAT_W-1:0] pattern;
        logic             wb_en;
        logic             arm;
    } inj_ctrl_t;

endpackage

// File: rtl/ecc_inj_regs.sv
module ecc_inj_regs
    import ecc_inj_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int CTRL_OFF = 0,
    parameter int STAT_OFF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              busy_i,
    input  logic              beat_hit_i,
    output logic [PAT_W-1:0]  pattern_o,
    output logic              wb_en_o,
    output logic              arm_o
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFF);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFF);

    inj_ctrl_t ctrl_d, ctrl_q;
    logic      ctrl_wr;

    assign ctrl_wr = reg_we && (reg_addr == CTRL_A);

    always_comb begin
        ctrl_d = ctrl_q;
        // a beat that consumed the arming disarms first
        if (beat_hit_i) begin
            ctrl_d.arm = 1'b0;
        end
        // a control write takes priority over the disarm
        if (ctrl_wr) begin
            ctrl_d.pattern = reg_wdata[PAT_LSB +: PAT_W];
            ctrl_d.wb_en   = reg_wdata[WB_BIT];
            if (!busy_i) begin
                ctrl_d.arm = reg_wdata[ARM_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CTRL_A) begin
            reg_rdata[PAT_LSB +: PAT_W] = ctrl_q.pattern;
            reg_rdata[WB_BIT]           = ctrl_q.wb_en;
            reg_rdata[ARM_BIT]          = ctrl_q.arm;
        end else if (reg_addr == STAT_A) begin
            reg_rdata[BUSY_BIT]         = busy_i;
        end
    end

    assign pattern_o = ctrl_q.pattern;
    assign wb_en_o   = ctrl_q.wb_en;
    assign arm_o     = ctrl_q.arm;

endmodule

// File: rtl/ecc_inj_wpath.sv
module ecc_inj_wpath #(
    parameter int DATA_W  = 64,
    parameter int CHECK_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid_i,
    input  logic [DATA_W-1:0]  data_i,
    input  logic [CHECK_W-1:0] check_i,
    input  logic               arm_i,
    input  logic [CHECK_W-1:0] pattern_i,
    output logic               valid_o,
    output logic [DATA_W-1:0]  data_o,
    output logic [CHECK_W-1:0] check_o,
    output logic               hit_o
);

    typedef struct packed {
        logic               valid;
        logic [DATA_W-1:0]  data;
        logic [CHECK_W-1:0] check;
    } beat_t;

    beat_t              beat_d, beat_q;
    logic [CHECK_W-1:0] flip;

    assign hit_o = valid_i & arm_i;

    for (genvar i = 0; i < CHECK_W; i++) begin : g_flip
        assign flip[i] = hit_o & pattern_i[i];
    end

    always_comb begin
        beat_d       = beat_q;
        beat_d.valid = valid_i;
        beat_d.data  = data_i;
        beat_d.check = check_i ^ flip;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else begin
            beat_q <= beat_d;
        end
    end

    assign valid_o = beat_q.valid;
    assign data_o  = beat_q.data;
    assign check_o = beat_q.check;

endmodule

// File: rtl/ecc_inject_ctrl.sv
module ecc_inject_ctrl
    import ecc_inj_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int ADDR_W   = 4,
    parameter int CTRL_OFF = 0,
    parameter int STAT_OFF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              busy_i,
    input  logic              wr_valid_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [PAT_W-1:0]  wr_check_i,
    output logic              wr_valid_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic [PAT_W-1:0]  wr_check_o,
    output logic              wb_en_o
);

    logic [PAT_W-1:0] inj_pat;
    logic             inj_arm;
    logic             inj_hit;

    ecc_inj_regs #(
        .ADDR_W  (ADDR_W),
        .CTRL_OFF(CTRL_OFF),
        .STAT_OFF(STAT_OFF)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy_i    (busy_i),
        .beat_hit_i(inj_hit),
        .pattern_o (inj_pat),
        .wb_en_o   (wb_en_o),
        .arm_o     (inj_arm)
    );

    ecc_inj_wpath #(
        .DATA_W (DATA_W),
        .CHECK_W(PAT_W)
    ) u_wpath (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (wr_valid_i),
        .data_i   (wr_data_i),
        .check_i  (wr_check_i),
        .arm_i    (inj_arm),
        .pattern_i(inj_pat),
        .valid_o  (wr_valid_o),
        .data_o   (wr_data_o),
        .check_o  (wr_check_o),
        .hit_o    (inj_hit)
    );

endmodule

// File: rtl/ecc_inj_chk.sv
module ecc_inj_chk #(
    parameter int DATA_W   = 64,
    parameter int CHECK_W  = 8,
    parameter int ADDR_W   = 4,
    parameter int CTRL_OFF = 0
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_we,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic               busy_i,
    input logic               wr_valid_i,
    input logic [DATA_W-1:0]  wr_data_i,
    input logic [CHECK_W-1:0] wr_check_i,
    input logic               wr_valid_o,
    input logic [DATA_W-1:0]  wr_data_o,
    input logic [CHECK_W-1:0] wr_check_o,
    input logic               wb_en_o,
    input logic               inj_arm,
    input logic [CHECK_W-1:0] inj_pat
);

    logic seen_q;
    logic ctl_wr;

    assign ctl_wr = reg_we && (reg_addr == ADDR_W'(CTRL_OFF));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> (!wr_valid_o && !wb_en_o));

    assert_busy_blocks_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!inj_arm && busy_i) |=> !inj_arm);

    assert_passthru_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !$past(inj_arm)) |->
            (wr_check_o == $past(wr_check_i) && wr_valid_o == $past(wr_valid_i)));

    assert_data_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (wr_data_o == $past(wr_data_i)));

    assert_corrupt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(inj_arm && wr_valid_i)) |->
            (wr_check_o == ($past(wr_check_i) ^ $past(inj_pat))));

    assert_one_shot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_arm && wr_valid_i && !ctl_wr) |=> !inj_arm);

    assert_idle_keeps_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_arm && !wr_valid_i && !ctl_wr) |=> inj_arm);

    assert_wb_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> $stable(wb_en_o));

endmodule

bind ecc_inject_ctrl ecc_inj_chk #(
    .DATA_W  (DATA_W),
    .CHECK_W (ecc_inj_pkg::PAT_W),
    .ADDR_W  (ADDR_W),
    .CTRL_OFF(CTRL_OFF)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .busy_i    (busy_i),
    .wr_valid_i(wr_valid_i),
    .wr_data_i (wr_data_i),
    .wr_check_i(wr_check_i),
    .wr_valid_o(wr_valid_o),
    .wr_data_o (wr_data_o),
    .wr_check_o(wr_check_o),
    .wb_en_o   (wb_en_o),
    .inj_arm   (inj_arm),
    .inj_pat   (inj_pat)
);

// File: tb/ecc_inject_ctrl_bench.sv
`timescale 1ns/1ps
module ecc_inject_ctrl_bench;

    localparam logic [3:0] A_CTRL = 4'h0;
    localparam logic [3:0] A_STAT = 4'h4;
    localparam logic [3:0] A_BAD  = 4'h8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        busy_i = 1'b0;
    logic        wr_valid_i = 1'b0;
    logic [63:0] wr_data_i = '0;
    logic [7:0]  wr_check_i = '0;
    logic        wr_valid_o;
    logic [63:0] wr_data_o;
    logic [7:0]  wr_check_o;
    logic        wb_en_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ecc_inject_ctrl u_ecc_inject_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy_i(busy_i),
        .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i), .wr_check_i(wr_check_i),
        .wr_valid_o(wr_valid_o), .wr_data_o(wr_data_o), .wr_check_o(wr_check_o),
        .wb_en_o(wb_en_o)
    );

    function automatic logic [31:0] ctl(input logic [7:0] pat, input logic wb, input logic arm);
        return {7'd0, wb, pat, 7'd0, arm, 8'd0};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.1;
        d = reg_rdata;
    endtask

    task automatic beat(input string tag, input logic [63:0] d, input logic [7:0] c,
                        input logic [7:0] exp_c);
        @(negedge clk);
        wr_valid_i = 1'b1; wr_data_i = d; wr_check_i = c;
        @(negedge clk);
        chk({tag, " valid"}, 64'(wr_valid_o), 64'd1);
        chk({tag, " data"}, wr_data_o, d);
        chk({tag, " check"}, 64'(wr_check_o), 64'(exp_c));
        wr_valid_i = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] r;
        bus_rd(A_CTRL, r);
        chk("R1 ctrl after reset", 64'(r), 64'd0);
        chk("R1 valid after reset", 64'(wr_valid_o), 64'd0);
        chk("R1 wb after reset", 64'(wb_en_o), 64'd0);
    endtask

    task automatic t_fields;
        logic [31:0] r;
        bus_wr(A_CTRL, 32'hFFFF_FEFF);
        bus_rd(A_CTRL, r);
        chk("R2 only fields stored", 64'(r), 64'(ctl(8'hFF, 1'b1, 1'b0)));
        chk("R9 wb port set", 64'(wb_en_o), 64'd1);
        bus_wr(A_CTRL, ctl(8'h00, 1'b0, 1'b0));
        bus_rd(A_CTRL, r);
        chk("R2 cleared", 64'(r), 64'd0);
        chk("R9 wb port clear", 64'(wb_en_o), 64'd0);
    endtask

    task automatic t_status;
        logic [31:0] r;
        busy_i = 1'b1;
        bus_rd(A_STAT, r);
        chk("R3 busy reads 1", 64'(r), 64'd1);
        busy_i = 1'b0;
        bus_wr(A_STAT, 32'hFFFF_FFFF);
        bus_rd(A_STAT, r);
        chk("R3 busy reads 0", 64'(r), 64'd0);
        bus_rd(A_CTRL, r);
        chk("R3 status write no effect", 64'(r), 64'd0);
    endtask

    task automatic t_unmapped;
        logic [31:0] r;
        bus_wr(A_BAD, ctl(8'hA5, 1'b1, 1'b1));
        bus_rd(A_BAD, r);
        chk("R11 unmapped read", 64'(r), 64'd0);
        bus_rd(A_CTRL, r);
        chk("R11 ctrl untouched", 64'(r), 64'd0);
        beat("R11 beat clean", 64'h1111_2222_3333_4444, 8'h5A, 8'h5A);
    endtask

    task automatic t_passthru;
        beat("R5 pass a", 64'hDEAD_BEEF_0123_4567, 8'h3C, 8'h3C);
        beat("R5 pass b", 64'h0, 8'hFF, 8'hFF);
    endtask

    task automatic t_inject;
        logic [31:0] r;
        bus_wr(A_CTRL, ctl(8'hF4, 1'b1, 1'b1));
        beat("R6 data-bit pattern", 64'hCAFE_F00D_1234_5678, 8'h0F, 8'h0F ^ 8'hF4);
        bus_rd(A_CTRL, r);
        chk("R7 arm cleared", 64'(r), 64'(ctl(8'hF4, 1'b1, 1'b0)));
        beat("R7 next beat clean", 64'hCAFE_F00D_1234_5678, 8'h0F, 8'h0F);
    endtask

    task automatic t_idle_keep;
        logic [31:0] r;
        bus_wr(A_CTRL, ctl(8'h80, 1'b1, 1'b1));
        repeat (5) @(negedge clk);
        bus_rd(A_CTRL, r);
        chk("R8 still armed", 64'(r[8]), 64'd1);
        beat("R8 check-bit pattern", 64'h5555_AAAA_5555_AAAA, 8'h00, 8'h80);
    endtask

    task automatic t_busy;
        logic [31:0] r;
        busy_i = 1'b1;
        bus_wr(A_CTRL, ctl(8'h55, 1'b0, 1'b1));
        bus_rd(A_CTRL, r);
        chk("R4 arm ignored while busy", 64'(r), 64'(ctl(8'h55, 1'b0, 1'b0)));
        busy_i = 1'b0;
        beat("R4 beat clean", 64'h7777_0000_7777_0000, 8'h21, 8'h21);
    endtask

    task automatic t_collide;
        logic [31:0] r;
        bus_wr(A_CTRL, ctl(8'h03, 1'b0, 1'b1));
        @(negedge clk);
        reg_we = 1'b1; reg_addr = A_CTRL; reg_wdata = ctl(8'h80, 1'b0, 1'b1);
        wr_valid_i = 1'b1; wr_data_i = 64'h0123_4567_89AB_CDEF; wr_check_i = 8'hC0;
        @(negedge clk);
        chk("R10 beat uses old pattern", 64'(wr_check_o), 64'(8'hC0 ^ 8'h03));
        reg_we = 1'b0; wr_valid_i = 1'b0;
        bus_rd(A_CTRL, r);
        chk("R10 rearmed", 64'(r), 64'(ctl(8'h80, 1'b0, 1'b1)));
        beat("R10 new pattern", 64'h0123_4567_89AB_CDEF, 8'hC0, 8'h40);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_status();
        t_unmapped();
        t_passthru();
        t_inject();
        t_idle_keep();
        t_busy();
        t_collide();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule